// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into a stream of column addresses, one per clock, for a synchronous DRAM style array. The command carries a starting column. A length code and an ordering bit give the burst length (1, 2, 4, 8 or a whole page) and the order of the columns. Fixed-length bursts stay inside an aligned group of columns whose size equals the burst length. A sequential burst steps through that group and wraps around inside it. An interleaved burst visits the group in the order given by XOR of the beat number with the low bits of the start column. A whole-page burst steps through every column of the row, wraps from the top column to column 0, and keeps going until something stops it.

A new command can arrive on any clock and replaces the burst in progress. A terminate input stops the burst. The generator raises `busy` while it presents addresses. It pulses `last_beat` on the final address of a fixed-length burst, and the controller around it uses that pulse to start auto precharge. Length codes 4 to 6 have no defined length and give a single-beat burst.

Top module: `burst_colgen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` and `last_beat` are 0 and `col_addr` is 0.
- R2: When `cmd_valid` is sampled high on an edge, `busy` is 1 after that edge and `col_addr` equals the `cmd_col` sampled with it.
- R3: Length code 0, 1, 2, 3 gives a burst of 1, 2, 4, 8 beats. `busy` stays high for exactly that many cycles and then falls, unless a command or terminate arrives first.
- R4: For a fixed length L of 2, 4 or 8, the column bits above bit log2(L)-1 never change during the burst.
- R5: With `ilv_mode` = 0, the low log2(L) bits of beat k equal (start + k) mod L.
- R6: With `ilv_mode` = 1, the low log2(L) bits of beat k equal start XOR k.
- R7: Length code 7 selects a whole-page burst. Each beat is the previous column plus one, wrapping from 255 to 0, and the burst never ends by itself. `ilv_mode` has no effect in this mode.
- R8: A command that arrives during a burst ends it. The next cycle presents the first beat of the new burst.
- R9: When `bst` is sampled high with `cmd_valid` low, `busy` is 0 after that edge. The beat shown before that edge was the last one. If `cmd_valid` and `bst` are high together, the command wins.
- R10: `last_beat` is high only together with the final beat of a fixed-length burst. It is never high during a whole-page burst.
- R11: `bl_code` and `ilv_mode` are sampled only together with a command. Changing them during a burst does not change the addresses that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Read or write command: starts a new burst |
| cmd_col | input | COL_W | Starting column of the command |
| bl_code | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=whole page |
| ilv_mode | input | 1 | 0 sequential order, 1 interleaved order |
| bst | input | 1 | Burst terminate |
| col_addr | output | COL_W | Current column address (registered) |
| busy | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle the assertions check these properties. A command loads its start column in the next cycle. A terminate drops `busy`. `busy` falls after a last beat. `last_beat` never shows up outside a burst or during a whole-page burst. A whole-page burst steps by exactly one column. The column bits above the block stay fixed between beats. The full order of the low bits cannot be checked that way, for either ordering. Mode inputs that change in the middle of a burst, truncation by a new command and a command arriving together with a terminate also need more than that. The bench's reference sequences show those cases, in directed cases and under random command traffic.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BLC_W = 3;
  localparam logic [BLC_W-1:0] BLC_ONE  = 3'd0;
  localparam logic [BLC_W-1:0] BLC_TWO  = 3'd1;
  localparam logic [BLC_W-1:0] BLC_FOUR = 3'd2;
  localparam logic [BLC_W-1:0] BLC_EIGHT = 3'd3;
  localparam logic [BLC_W-1:0] BLC_FULL = 3'd7;
endpackage

// File: rtl/burst_mode_dec.sv
// Turns a length code into a wrap mask (L-1) and a whole-page flag.
module burst_mode_dec import burst_pkg::*; #(
  parameter int COL_W = 8,
  parameter int FIXED_LOG_MAX = 3
) (
  input  logic [BLC_W-1:0] code,
  output logic [COL_W-1:0] mask,
  output logic             full
);
  always_comb begin
    full = (code == BLC_FULL);
    mask = '0;
    if (full)
      mask = '1;
    else if (int'(code) <= FIXED_LOG_MAX)
      mask = (COL_W'(1) << code) - COL_W'(1);
  end
endmodule

// File: rtl/burst_order.sv
// Column for a given beat: the bits outside the mask come from start,
// the bits inside come from the sequential or interleaved offset.
module burst_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low;
  always_comb begin
    low = ilv ? (start ^ beat) : (start + beat);
    col = (start & ~mask) | (low & mask);
  end
endmodule

// File: rtl/burst_seq.sv
// Burst state: latched mode, start column, beat index, busy and last flags.
module burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [COL_W-1:0] cmd_mask,
  input  logic             cmd_full,
  input  logic             cmd_ilv,
  input  logic             bst,
  output logic [COL_W-1:0] n_start,
  output logic [COL_W-1:0] n_beat,
  output logic [COL_W-1:0] n_mask,
  output logic             n_ilv,
  output logic             n_busy,
  output logic             busy_q,
  output logic             last_q
);
  logic [COL_W-1:0] start_q, beat_q, mask_q;
  logic             full_q, ilv_q;
  logic             n_full, n_last, at_end;

  always_comb begin
    n_start = start_q;
    n_beat  = beat_q;
    n_mask  = mask_q;
    n_full  = full_q;
    n_ilv   = ilv_q;
    n_busy  = busy_q;
    at_end  = busy_q && !full_q && (beat_q == mask_q);
    if (cmd_valid) begin
      n_start = cmd_col;
      n_beat  = '0;
      n_mask  = cmd_mask;
      n_full  = cmd_full;
      n_ilv   = cmd_ilv & ~cmd_full;
      n_busy  = 1'b1;
    end else if (bst || at_end) begin
      n_busy  = 1'b0;
    end else if (busy_q) begin
      n_beat  = beat_q + COL_W'(1);
    end
    n_last = n_busy && !n_full && (n_beat == n_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      start_q <= n_start;
      beat_q  <= n_beat;
      mask_q  <= n_mask;
      full_q  <= n_full;
      ilv_q   <= n_ilv;
      busy_q  <= n_busy;
      last_q  <= n_last;
    end
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen import burst_pkg::*; #(
  parameter int COL_W = 8,
  parameter int FIXED_LOG_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [BLC_W-1:0] bl_code,
  input  logic             ilv_mode,
  input  logic             bst,
  output logic [COL_W-1:0] col_addr,
  output logic             busy,
  output logic             last_beat
);
  logic [COL_W-1:0] dec_mask, n_start, n_beat, n_mask, nxt_col, col_q;
  logic             dec_full, n_ilv, n_busy;

  burst_mode_dec #(.COL_W(COL_W), .FIXED_LOG_MAX(FIXED_LOG_MAX)) u_dec (
    .code(bl_code), .mask(dec_mask), .full(dec_full)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .cmd_mask(dec_mask), .cmd_full(dec_full), .cmd_ilv(ilv_mode), .bst(bst),
    .n_start(n_start), .n_beat(n_beat), .n_mask(n_mask), .n_ilv(n_ilv),
    .n_busy(n_busy), .busy_q(busy), .last_q(last_beat)
  );

  burst_order #(.COL_W(COL_W)) u_ord (
    .start(n_start), .beat(n_beat), .mask(n_mask), .ilv(n_ilv), .col(nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst)         col_q <= '0;
    else if (n_busy) col_q <= nxt_col;
  end

  assign col_addr = col_q;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk import burst_pkg::*; #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [COL_W-1:0] cmd_col,
  input logic [BLC_W-1:0] bl_code,
  input logic             bst,
  input logic [COL_W-1:0] col_addr,
  input logic             busy,
  input logic             last_beat
);
  logic             fp_q;
  logic [COL_W-1:0] mq;

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_q <= 1'b0;
      mq   <= '0;
    end else if (cmd_valid) begin
      fp_q <= (bl_code == BLC_FULL);
      case (bl_code)
        BLC_TWO:   mq <= COL_W'(1);
        BLC_FOUR:  mq <= COL_W'(3);
        BLC_EIGHT: mq <= COL_W'(7);
        BLC_FULL:  mq <= '1;
        default:   mq <= '0;
      endcase
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !last_beat && col_addr == '0));

  // R2
  cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (busy && col_addr == $past(cmd_col)));

  // R9
  bst_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (bst && !cmd_valid) |=> !busy);

  // R10
  last_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> busy);

  // R10
  fp_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && fp_q) |-> !last_beat);

  // R3
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !cmd_valid) |=> !busy);

  // R7
  fp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && fp_q && !cmd_valid && !bst) |=>
      (busy && col_addr == $past(col_addr) + COL_W'(1)));

  // R4
  block_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_beat && !cmd_valid && !bst) |=>
      (busy && (col_addr & ~mq) == ($past(col_addr) & ~mq)));
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
  .bl_code(bl_code), .bst(bst), .col_addr(col_addr), .busy(busy),
  .last_beat(last_beat)
);

// File: tb/burst_colgen_test.sv
`timescale 1ns/1ps
module burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_col = '0;
  logic [2:0] bl_code = '0;
  logic       ilv_mode = 1'b0;
  logic       bst = 1'b0;
  logic [7:0] col_addr;
  logic       busy, last_beat;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  bit m_busy = 0, m_ilv = 0;
  int m_start = 0, m_k = 0, m_len = 1;

  always #2.5 clk = ~clk;

  burst_colgen uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .bl_code(bl_code), .ilv_mode(ilv_mode), .bst(bst),
    .col_addr(col_addr), .busy(busy), .last_beat(last_beat)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string t, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 256;
    endcase
  endfunction

  // column expected for beat k, straight from R4..R7
  function automatic int want_col(int s, int k, int len, bit il);
    int base, off;
    if (len == 256) return (s + k) % 256;
    off  = s % len;
    base = s - off;
    if (il) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  task automatic step(bit c, int col, int code, bit il, bit b);
    bit exp_last;
    int exp_c;
    cmd_valid = c; cmd_col = 8'(col); bl_code = 3'(code);
    ilv_mode = il; bst = b;
    if (c) begin
      m_busy = 1; m_start = col; m_k = 0; m_len = len_of(code); m_ilv = il;
    end else if (b) begin
      m_busy = 0;
    end else if (m_busy) begin
      if (m_len != 256 && m_k == m_len - 1) m_busy = 0;
      else m_k = (m_k + 1) % 256;
    end
    @(negedge clk);
    exp_last = m_busy && m_len != 256 && m_k == m_len - 1;
    chk(busy == m_busy, {tag, " busy"}, int'(busy), int'(m_busy));
    chk(last_beat == exp_last, "R10 last_beat", int'(last_beat), int'(exp_last));
    if (m_busy) begin
      exp_c = want_col(m_start, m_k, m_len, m_ilv);
      chk(int'(col_addr) == exp_c, {tag, " col"}, int'(col_addr), exp_c);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(!busy && !last_beat && col_addr == 8'd0, "R1 during reset",
        int'(col_addr) + int'(busy) + int'(last_beat), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !last_beat && col_addr == 8'd0, "R1 after reset",
        int'(col_addr) + int'(busy) + int'(last_beat), 0);

    tag = "R2 R4 R5 seq";
    step(1, 5, 3, 0, 0); idle(9);
    step(1, 8'h37, 1, 0, 0); idle(3);
    step(1, 8'h9e, 2, 0, 0); idle(5);

    tag = "R6 ilv";
    step(1, 5, 3, 1, 0); idle(9);
    step(1, 8'h43, 1, 1, 0); idle(2);
    step(1, 8'hd6, 2, 1, 0); idle(5);

    tag = "R7 page";
    step(1, 250, 7, 1, 0); idle(12);
    step(0, 0, 0, 0, 1); idle(2);

    tag = "R8 truncate";
    step(1, 16, 3, 0, 0); idle(2);
    step(1, 100, 2, 1, 0); step(1, 200, 1, 0, 0); idle(4);

    tag = "R9 terminate";
    step(1, 40, 7, 0, 0); idle(3);
    step(0, 0, 0, 0, 1); idle(2);
    step(1, 8, 2, 0, 1); idle(5);
    step(1, 60, 3, 1, 0); step(0, 0, 0, 0, 1); idle(2);

    tag = "R10 single";
    step(1, 77, 0, 0, 0); step(1, 78, 0, 1, 0); idle(2);

    tag = "R11 mode hold";
    step(1, 3, 3, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, i % 4, i[0], 0);
    step(1, 130, 7, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1); idle(1);

    tag = "R3 random";
    begin
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        int r = $urandom_range(99);
        int codes[5] = '{0, 1, 2, 3, 7};
        int cd = codes[$urandom_range(4)];
        bit c = (r < 15);
        bit b = (r >= 15 && r < 20) || (r < 3);
        step(c, $urandom_range(255), cd, 1'($urandom_range(1)), b);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule